// File: doc/BRIEF.md
# Interrupt Status and Master Control Register Block

This block gathers single-cycle event pulses from the rest of an adapter into sticky status bits. An enable register masks those bits, and one interrupt line is driven from the result. Software reaches the block through a word-addressed register port. The status can be read at two addresses: one returns the bits and acknowledges them, the other only observes them. An event that fires in the same cycle as an acknowledge is never lost.

A master control register holds the run enables for the receive, transmit and DMA engines, a transmit lock/streaming select and a 3-bit interrupt routing field. Two of its bits start a holdoff: after they are written, the interrupt line stays low for a fixed number of clock cycles. The short and long windows are parameters, by default 0.5 ms and 1 ms at 100 MHz.

Address 0 returns a read-only identification word. Any write to address 0 returns the block to its reset state.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After the reset input is asserted, status, enable and master control are zero, the interrupt line is low, every engine output is low and rdata_o is zero.
- R2: A one-cycle pulse on evt_i bit k sets status bit k, and the bit stays set until it is acknowledged or the block is reset. The layout is: bit 0 statistics, 1 line interface, 2 service, 3 transmit DMA done, 4 receive DMA done, 5 DMA error, 6 DMA length error, 7 identifier mismatch, 8 DMA overflow, bits 16:9 transmit channels 0..7.
- R3: A read of address 1 returns the status in bits 16:0 and clears exactly the bits it returned. A bit whose event arrives in the same cycle as that read is left set.
- R4: A read of address 2 returns the status in bits 16:0 and leaves it unchanged.
- R5: Address 3 is the enable register, with the same bit layout as the status and read back in bits 16:0. With no holdoff running, irq_o is high exactly when some status bit and its enable bit are both set.
- R6: In the master control register at address 4, bit 2 drives rx_en_o, bit 3 tx_en_o, bit 4 dma_en_o, bit 5 tx_lock_o (1 lock, 0 streaming) and bits 8:6 int_sel_o. Bits 8:0 read back as written.
- R7: A write to address 4 with bit 1 set holds irq_o low for HOLD_LONG_CYC cycles after the write edge. With only bit 0 set, the hold is HOLD_SHORT_CYC cycles. A later holdoff write reloads the window.
- R8: A read of address 0 returns VERSION in bits 31:27, BOARD_ID in bits 9:7 and DAUGHTER_ID in bits 4:0, with zeros elsewhere.
- R9: Any write to address 0 clears status, enable, master control and the holdoff window at that edge. An event arriving in the same cycle is dropped. The identification word is unchanged.
- R10: Writes to addresses 1 and 2 change nothing. Reads of addresses 5 and above return zero.
- R11: rdata_o takes the read value at the clock edge where rd_en_i is sampled high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | 9+N_TXCH | Event pulses, one per status bit |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receive engine enable |
| tx_en_o | output | 1 | Transmit engine enable |
| dma_en_o | output | 1 | DMA engine enable |
| tx_lock_o | output | 1 | Transmit lock (1) or streaming (0) |
| int_sel_o | output | 3 | Interrupt routing select |

## Verification
The bench builds the block with eight transmit channels, so the full 17-bit status layout and its top bit are exercised. HOLD_SHORT_CYC is set to 12 and HOLD_LONG_CYC to 30, which makes both holdoff windows, their last gated cycle, their reload and a reset that cuts one short reachable within a few dozen cycles. The identification fields are set to distinct non-zero patterns, so each field's position in the ID word is checked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW       = 32;
  localparam int BASE_EVT = 9;   // fixed event bits below the per-channel bits
  localparam int MST_W    = 9;

  localparam int A_ID   = 0;
  localparam int A_ACK  = 1;
  localparam int A_PEEK = 2;
  localparam int A_ENA  = 3;
  localparam int A_MST  = 4;

  typedef struct packed {
    logic [2:0] sel;
    logic       lock;
    logic       dma;
    logic       tx;
    logic       rx;
    logic       hold_long;
    logic       hold_short;
  } mst_t;
endpackage

// File: rtl/irqc_status.sv
module irqc_status #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all,
  input  logic [W-1:0] ack_mask,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic bit_q, bit_d, bit_ce;

    always_comb begin
      bit_ce = clr_all | ack_mask[g] | evt[g];
      bit_d  = clr_all ? 1'b0 : (evt[g] | (bit_q & ~ack_mask[g]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_ce) bit_q <= bit_d;
    end

    assign q[g] = bit_q;
  end
endmodule

// File: rtl/irqc_holdoff.sv
module irqc_holdoff #(
  parameter int SHORT_CYC = 50000,
  parameter int LONG_CYC  = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load_short,
  input  logic load_long,
  output logic busy_o
);
  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    cnt_ce = clr | load_short | load_long | (cnt_q != '0);
    if (clr)             cnt_d = '0;
    else if (load_long)  cnt_d = LONG_V;
    else if (load_short) cnt_d = SHORT_V;
    else                 cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int         ADDR_W         = 4,
  parameter int         N_TXCH         = 8,
  parameter int         HOLD_SHORT_CYC = 50000,
  parameter int         HOLD_LONG_CYC  = 100000,
  parameter logic [4:0] VERSION        = 5'h01,
  parameter logic [2:0] BOARD_ID       = 3'h0,
  parameter logic [4:0] DAUGHTER_ID    = 5'h00
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 rd_en_i,
  input  logic                                 wr_en_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [31:0]                          wdata_i,
  output logic [31:0]                          rdata_o,
  input  logic [irqc_pkg::BASE_EVT+N_TXCH-1:0] evt_i,
  output logic                                 irq_o,
  output logic                                 rx_en_o,
  output logic                                 tx_en_o,
  output logic                                 dma_en_o,
  output logic                                 tx_lock_o,
  output logic [2:0]                           int_sel_o
);
  import irqc_pkg::*;

  localparam int STAT_W = BASE_EVT + N_TXCH;
  localparam logic [31:0] ID_WORD =
    {VERSION, 17'b0, BOARD_ID, 2'b0, DAUGHTER_ID};

  // address decode
  logic hit_id, hit_ack, hit_peek, hit_ena, hit_mst;
  assign hit_id   = (addr_i == ADDR_W'(A_ID));
  assign hit_ack  = (addr_i == ADDR_W'(A_ACK));
  assign hit_peek = (addr_i == ADDR_W'(A_PEEK));
  assign hit_ena  = (addr_i == ADDR_W'(A_ENA));
  assign hit_mst  = (addr_i == ADDR_W'(A_MST));

  logic soft_rst, ack_rd, ena_wr, mst_wr;
  assign soft_rst = wr_en_i & hit_id;
  assign ack_rd   = rd_en_i & hit_ack;
  assign ena_wr   = wr_en_i & hit_ena;
  assign mst_wr   = wr_en_i & hit_mst;

  // sticky status
  logic [STAT_W-1:0] stat_q, ack_mask;
  assign ack_mask = ack_rd ? stat_q : '0;

  irqc_status #(.W(STAT_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_all  (soft_rst),
    .ack_mask (ack_mask),
    .evt      (evt_i),
    .q        (stat_q)
  );

  // enable and master control
  logic [STAT_W-1:0] en_q, en_d;
  logic              en_ce;
  mst_t              mst_q, mst_d, mst_wv;
  logic              mst_ce;

  assign mst_wv = mst_t'(wdata_i[MST_W-1:0]);

  always_comb begin
    en_ce  = soft_rst | ena_wr;
    en_d   = soft_rst ? '0 : wdata_i[STAT_W-1:0];
    mst_ce = soft_rst | mst_wr;
    mst_d  = soft_rst ? mst_t'('0) : mst_wv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mst_q <= mst_t'('0);
    else if (mst_ce) mst_q <= mst_d;
  end

  // holdoff window
  logic hold_busy;

  irqc_holdoff #(
    .SHORT_CYC (HOLD_SHORT_CYC),
    .LONG_CYC  (HOLD_LONG_CYC)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .load_short (mst_wr & mst_wv.hold_short),
    .load_long  (mst_wr & mst_wv.hold_long),
    .busy_o     (hold_busy)
  );

  // read path
  logic [31:0] rd_mux, rdata_q;

  always_comb begin
    rd_mux = '0;
    if (hit_id)                rd_mux = ID_WORD;
    else if (hit_ack | hit_peek) rd_mux[STAT_W-1:0] = stat_q;
    else if (hit_ena)          rd_mux[STAT_W-1:0] = en_q;
    else if (hit_mst)          rd_mux[MST_W-1:0]  = mst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign irq_o     = (|(stat_q & en_q)) & ~hold_busy;
  assign rx_en_o   = mst_q.rx;
  assign tx_en_o   = mst_q.tx;
  assign dma_en_o  = mst_q.dma;
  assign tx_lock_o = mst_q.lock;
  assign int_sel_o = mst_q.sel;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int ADDR_W = 4,
  parameter int STAT_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [STAT_W-1:0] evt,
  input logic [STAT_W-1:0] stat,
  input logic [STAT_W-1:0] ena,
  input logic              irq,
  input logic              rx_en,
  input logic [31:0]       id_word
);
  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt && !(wr_en && addr == ADDR_W'(0))) |=> ((stat & $past(evt)) == $past(evt)));

  assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(1)) |=> (stat == $past(evt)));

  assert_peek_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(2)) |=> ((stat & $past(stat)) == $past(stat)));

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(stat & ena)));

  assert_master_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=> (rx_en == $past(wdata[2])));

  assert_holdoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4) && |wdata[1:0]) |=> !irq);

  assert_id_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(0)) |=> (rdata == id_word));

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0)) |=> (stat == '0 && ena == '0 && !irq));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind irq_ctrl_regs irqc_checker #(
  .ADDR_W (ADDR_W),
  .STAT_W (irqc_pkg::BASE_EVT + N_TXCH)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_en   (rd_en_i),
  .wr_en   (wr_en_i),
  .addr    (addr_i),
  .wdata   (wdata_i),
  .rdata   (rdata_o),
  .evt     (evt_i),
  .stat    (stat_q),
  .ena     (en_q),
  .irq     (irq_o),
  .rx_en   (rx_en_o),
  .id_word (ID_WORD)
);

// File: tb/sim_irq_ctrl_regs.sv
module sim_irq_ctrl_regs;
  localparam int         AW    = 4;
  localparam int         NCH   = 8;
  localparam int         SW    = 9 + NCH;
  localparam int         SHORT = 12;
  localparam int         LONG  = 30;
  localparam logic [4:0] VER   = 5'h13;
  localparam logic [2:0] BRD   = 3'h5;
  localparam logic [4:0] DTR   = 5'h0A;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_en = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [SW-1:0] evt = '0;
  logic          irq, rx_en, tx_en, dma_en, tx_lock;
  logic [2:0]    int_sel;

  always #5 clk = ~clk;

  irq_ctrl_regs #(
    .ADDR_W(AW), .N_TXCH(NCH), .HOLD_SHORT_CYC(SHORT), .HOLD_LONG_CYC(LONG),
    .VERSION(VER), .BOARD_ID(BRD), .DAUGHTER_ID(DTR)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq),
    .rx_en_o(rx_en), .tx_en_o(tx_en), .dma_en_o(dma_en), .tx_lock_o(tx_lock),
    .int_sel_o(int_sel)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [SW-1:0] m_stat = '0, m_en = '0;
  logic [8:0]    m_mst = '0;
  int            m_hold = 0;
  logic [31:0]   m_rdata = '0;

  function automatic logic [31:0] id_word();
    return {VER, 17'b0, BRD, 2'b0, DTR};
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a);
    logic [31:0] v = '0;
    case (a)
      4'd0: v = id_word();
      4'd1, 4'd2: v[SW-1:0] = m_stat;
      4'd3: v[SW-1:0] = m_en;
      4'd4: v[8:0] = m_mst;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string rd_tag(input logic [AW-1:0] a);
    case (a)
      4'd0: return "R8";
      4'd1: return "R3";
      4'd2: return "R4";
      4'd3: return "R5";
      4'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock cycle: drive, update model at the edge, check after the edge
  task automatic step(input bit rd, input bit wr, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic [SW-1:0] ev, input string tag = "");
    logic [31:0]   rv;
    logic [SW-1:0] clr;
    logic          exp_irq;
    string         t;
    @(negedge clk);
    rd_en = rd; wr_en = wr; addr = a; wdata = wd; evt = ev;
    rv = exp_read(a);
    @(posedge clk);
    if (rd) m_rdata = rv;
    if (wr && a == 4'd0) begin
      m_stat = '0; m_en = '0; m_mst = '0; m_hold = 0;
    end else begin
      clr = (rd && a == 4'd1) ? m_stat : '0;
      m_stat = (m_stat & ~clr) | ev;
      if (wr && a == 4'd3) m_en = wd[SW-1:0];
      if (wr && a == 4'd4) begin
        m_mst = wd[8:0];
        if (wd[1])      m_hold = LONG;
        else if (wd[0]) m_hold = SHORT;
        else if (m_hold > 0) m_hold--;
      end else if (m_hold > 0) m_hold--;
    end
    #2;
    t = (tag != "") ? tag : (rd ? rd_tag(a) : "R11");
    chk(rdata == m_rdata, t, rdata, m_rdata);
    exp_irq = (|(m_stat & m_en)) && (m_hold == 0);
    t = (tag != "") ? tag : ((m_hold > 0) ? "R7" : "R5");
    chk(irq == exp_irq, t, {31'b0, irq}, {31'b0, exp_irq});
    t = (tag != "") ? tag : "R6";
    chk({int_sel, tx_lock, dma_en, tx_en, rx_en} == m_mst[8:2], t,
        {25'b0, int_sel, tx_lock, dma_en, tx_en, rx_en}, {25'b0, m_mst[8:2]});
  endtask

  task automatic idle(input string tag = "");
    step(1'b0, 1'b0, '0, '0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(irq == 1'b0, "R1", {31'b0, irq}, 0);
    chk(rdata == 32'h0, "R1", rdata, 0);
    chk({int_sel, tx_lock, dma_en, tx_en, rx_en} == 7'h0, "R1",
        {25'b0, int_sel, tx_lock, dma_en, tx_en, rx_en}, 0);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 4'd2, '0, '0, "R1");
    step(1'b1, 1'b0, 4'd3, '0, '0, "R1");
    step(1'b1, 1'b0, 4'd4, '0, '0, "R1");
    step(1'b1, 1'b0, 4'd0, '0, '0);           // R8 id word

    // R2: each status bit alone, then acknowledge it
    for (int k = 0; k < SW; k++) begin
      step(1'b0, 1'b0, '0, '0, SW'(1) << k, "R2");
      idle("R2");
      step(1'b1, 1'b0, 4'd2, '0, '0, "R2");
      step(1'b1, 1'b0, 4'd1, '0, '0, "R2");
    end

    // R3: event in the same cycle as an acknowledge read survives
    step(1'b0, 1'b0, '0, '0, 17'h00011);
    step(1'b1, 1'b0, 4'd1, '0, 17'h10001, "R3");
    step(1'b1, 1'b0, 4'd2, '0, '0, "R3");

    // R5: enable masking
    step(1'b0, 1'b1, 4'd3, 32'hFFFE_0004, '0);
    step(1'b1, 1'b0, 4'd3, '0, '0, "R5");
    step(1'b0, 1'b0, '0, '0, 17'h00008, "R5");  // not enabled: no irq
    step(1'b0, 1'b0, '0, '0, 17'h00004, "R5");  // enabled: irq

    // R7: short and long windows, reload, exact last cycle
    step(1'b0, 1'b1, 4'd4, 32'h0000_001D, '0, "R7");
    for (int i = 0; i < SHORT + 2; i++) idle("R7");
    step(1'b0, 1'b1, 4'd4, 32'h0000_0016, '0, "R7");
    for (int i = 0; i < 10; i++) idle("R7");
    step(1'b0, 1'b1, 4'd4, 32'h0000_01E3, '0, "R7");
    for (int i = 0; i < LONG + 2; i++) idle("R7");

    // R10: writes to status addresses ignored, high addresses read zero
    step(1'b0, 1'b1, 4'd1, 32'hFFFF_FFFF, '0, "R10");
    step(1'b0, 1'b1, 4'd2, 32'h0000_0000, '0, "R10");
    step(1'b1, 1'b0, 4'd2, '0, '0, "R10");
    step(1'b1, 1'b0, 4'd7, '0, '0, "R10");
    step(1'b1, 1'b0, 4'd15, '0, '0, "R10");

    // R9: soft reset mid-holdoff with a coincident event
    step(1'b0, 1'b1, 4'd4, 32'h0000_003E, '0);
    step(1'b0, 1'b1, 4'd0, 32'h1234_5678, 17'h1FFFF, "R9");
    step(1'b1, 1'b0, 4'd2, '0, '0, "R9");
    step(1'b1, 1'b0, 4'd3, '0, '0, "R9");
    step(1'b1, 1'b0, 4'd4, '0, '0, "R9");
    step(1'b1, 1'b0, 4'd0, '0, '0, "R9");

    // random mix
    for (int n = 0; n < 1500; n++) begin
      int unsigned op = $urandom % 8;
      logic [SW-1:0] ev = SW'($urandom & $urandom & $urandom);
      r = $urandom;
      case (op)
        0, 1: step(1'b0, 1'b0, '0, '0, ev);
        2: step(1'b1, 1'b0, 4'd1, '0, ev);
        3: step(1'b1, 1'b0, 4'd2, '0, ev);
        4: step(1'b0, 1'b1, 4'd3, r, ev);
        5: step(1'b0, 1'b1, 4'd4, ($urandom % 4 == 0) ? r : (r & ~32'h3), ev);
        6: step(1'b0, 1'b1, AW'(($urandom % 2) ? 1 : 2 + 3 * ($urandom % 2)), r, ev);
        default: begin
          if ($urandom % 16 == 0) step(1'b0, 1'b1, 4'd0, r, ev);
          else step(1'b1, 1'b0, AW'($urandom % 8), '0, ev);
        end
      endcase
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule